// File: doc/BRIEF.md
# Reset and Boot-Mode Latch Controller

This block sits between the chip's external reset pin and everything else that needs an internal reset. It brings the active-low reset pin into the system clock domain through a short flop chain. It measures how long the pin stayed low and stretches the internal reset so it always lasts at least a set number of clock cycles. When a reset of valid length ends, the block captures the three operating-mode pins and the flash write-enable pin and decides which operating mode the chip runs in.

One mode code, when seen together with write-enable high, puts the chip into boot mode. Boot mode is sticky. A later external reset with write-enable still high keeps it, whatever the mode pins say. A watchdog reset request keeps it as well. The only way out is an external reset of valid length that ends with write-enable low. A watchdog reset in boot mode pulses the internal reset and then raises a one-cycle request to restart the boot program. During any internal reset the enable for the address-strobe, read and write drivers is held off. That enable comes back one cycle after the reset ends, so the bus pins cannot fight external logic while the mode is changing.

Top module: `rstboot_ctrl`

## Requirements
- R1: A falling edge on `rst_pin_n` reaches the internal reset through a two-flop synchronizer. The pin is driven low before clock edge 1, and `int_rst_n` is first low after edge 3.
- R2: An external low pulse of N cycles gives an internal reset of max(N, MIN_RST_CYC) cycles. The default for MIN_RST_CYC is 20.
- R3: When an external reset of at least MIN_RST_CYC cycles ends and boot mode is not latched, `op_mode` takes the value that `mode_pins` had at release.
- R4: An external pulse shorter than MIN_RST_CYC is invalid. The internal reset is still stretched, but `op_mode` and `boot_mode` keep their previous values.
- R5: Boot mode is entered at a valid release only when `mode_pins` equals BOOT_MODE (default 3'b110) and `wren_pin` is 1. The boot code with `wren_pin` at 0 latches as an ordinary mode with `boot_mode` at 0.
- R6: While boot mode is latched, a valid external reset released with `wren_pin` at 1 leaves `boot_mode` at 1 and `op_mode` unchanged, whatever the mode pins are.
- R7: While boot mode is latched, a valid external reset released with `wren_pin` at 0 clears `boot_mode` and loads `op_mode` from `mode_pins`.
- R8: A one-cycle `wdt_req` while `int_rst_n` is high holds `int_rst_n` low for WDT_RST_CYC cycles (default 8). With boot mode latched, `boot_restart` is then high for exactly the first cycle that `int_rst_n` is high again. `op_mode` and `boot_mode` are unchanged and the mode pins are not read.
- R9: A watchdog reset with boot mode not latched never raises `boot_restart` and leaves `op_mode` unchanged.
- R10: Changes on `mode_pins` or `wren_pin` while `int_rst_n` is high have no effect on `op_mode` or `boot_mode`.
- R11: `bus_drv_en` is 0 whenever `int_rst_n` is 0. It is still 0 in the first cycle after `int_rst_n` rises and becomes 1 in the second cycle.
- R12: While `por_n` is low, `int_rst_n`, `bus_drv_en` and `boot_restart` are 0, `boot_mode` is 0 and `op_mode` is POR_MODE (default 3'b101). A pin that is already high at power-on gives a short pulse, which samples nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| rst_pin_n | input | 1 | Raw external reset pin, active low |
| mode_pins | input | MODE_W | Operating-mode select pins |
| wren_pin | input | 1 | Flash write-enable pin |
| wdt_req | input | 1 | Watchdog reset request, one cycle, synchronous |
| int_rst_n | output | 1 | Internal reset, active low |
| op_mode | output | MODE_W | Latched operating mode |
| boot_mode | output | 1 | Boot mode is latched |
| boot_restart | output | 1 | One-cycle request to restart the boot program |
| bus_drv_en | output | 1 | Enable for the address-strobe, read and write drivers |

## Verification
The hardest case to reach is the watchdog reset while boot mode is latched. It needs three steps in order: a valid external reset with the boot code and write-enable high, then the mode pins and write-enable moved to values that would clear boot mode, then a watchdog request. The bench walks the external resets through a vector table, then builds this sequence as directed steps. It checks that the restart pulse lands in exactly the first cycle after the internal reset ends, and that the changed pins are not sampled. Glitches are made by releasing the pin after 3 or 5 cycles, which exercises the stretch path that samples nothing.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_EXT = 2'd1,
    ST_WDT = 2'd2
  } rbc_state_e;
endpackage

// File: rtl/rbc_sync.sv
module rbc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q[g] <= RST_VAL;
        end else begin
          if (g == 0) chain_q[g] <= d_i;
          else        chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rbc_seq.sv
module rbc_seq
  import rbc_pkg::*;
#(
  parameter int MIN_CYC = 20,
  parameter int WDT_CYC = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin_lo_i,
  input  logic wdt_req_i,
  output logic rst_hold_o,
  output logic rel_valid_o,
  output logic wdt_done_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam int WW = $clog2(WDT_CYC + 1);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);
  localparam logic [WW-1:0] WDT_V = WW'(WDT_CYC);

  rbc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          short_q, short_d;
  logic          rel_valid, wdt_done;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    wcnt_d    = wcnt_q;
    short_d   = short_q;
    rel_valid = 1'b0;
    wdt_done  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (pin_lo_i) begin
          state_d = ST_EXT;
          cnt_d   = CW'(1);
          short_d = 1'b0;
        end else if (wdt_req_i) begin
          state_d = ST_WDT;
          wcnt_d  = WW'(1);
        end
      end
      ST_EXT: begin
        if (pin_lo_i) begin
          if (short_q) begin
            // a fresh pulse after a rejected one starts a new count
            cnt_d   = CW'(1);
            short_d = 1'b0;
          end else if (cnt_q < MIN_V) begin
            cnt_d = cnt_q + CW'(1);
          end
        end else if (cnt_q >= MIN_V) begin
          state_d   = ST_RUN;
          rel_valid = !short_q;
        end else begin
          // released early: stretch, remember the pulse was too short
          short_d = 1'b1;
          cnt_d   = cnt_q + CW'(1);
        end
      end
      ST_WDT: begin
        if (pin_lo_i) begin
          state_d = ST_EXT;
          cnt_d   = CW'(1);
          short_d = 1'b0;
        end else if (wcnt_q == WDT_V) begin
          state_d  = ST_RUN;
          wdt_done = 1'b1;
        end else begin
          wcnt_d = wcnt_q + WW'(1);
        end
      end
      default: state_d = ST_EXT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_EXT;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wcnt_q  <= wcnt_d;
      short_q <= short_d;
    end
  end

  assign rst_hold_o  = (state_q != ST_RUN);
  assign rel_valid_o = rel_valid;
  assign wdt_done_o  = wdt_done;

  // checker: length of the current external hold, independent of cnt_q
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (state_q != ST_EXT)  run_q <= '0;
    else if (run_q < MIN_V)      run_q <= run_q + CW'(1);
  end

  p_min_width_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_EXT && state_d == ST_RUN) |-> (run_q >= MIN_V - CW'(1)));

  p_wdt_len_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_WDT && state_d == ST_RUN) |-> (wcnt_q == WDT_V));
endmodule

// File: rtl/rbc_mode_latch.sv
module rbc_mode_latch #(
  parameter int                MODE_W   = 3,
  parameter logic [MODE_W-1:0] BOOT_ENC = 3'b110,
  parameter logic [MODE_W-1:0] DEF_MODE = 3'b101
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rel_valid_i,
  input  logic              wdt_done_i,
  input  logic [MODE_W-1:0] mode_pins_i,
  input  logic              wren_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              boot_o,
  output logic              restart_o
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              boot_q, boot_d;
  logic              restart_q, restart_d;
  logic              load_en;

  always_comb begin
    load_en = rel_valid_i;
    mode_d  = mode_q;
    boot_d  = boot_q;
    if (boot_q) begin
      if (!wren_i) begin
        boot_d = 1'b0;
        mode_d = mode_pins_i;
      end
    end else begin
      mode_d = mode_pins_i;
      boot_d = (mode_pins_i == BOOT_ENC) && wren_i;
    end
    restart_d = wdt_done_i && boot_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= DEF_MODE;
      boot_q <= 1'b0;
    end else if (load_en) begin
      mode_q <= mode_d;
      boot_q <= boot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) restart_q <= 1'b0;
    else         restart_q <= restart_d;
  end

  assign mode_o    = mode_q;
  assign boot_o    = boot_q;
  assign restart_o = restart_q;

  p_wdt_keeps_state_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    wdt_done_i |=> ($stable(mode_q) && $stable(boot_q)));
endmodule

// File: rtl/rstboot_ctrl.sv
module rstboot_ctrl #(
  parameter int                MIN_RST_CYC = 20,
  parameter int                WDT_RST_CYC = 8,
  parameter int                SYNC_STAGES = 2,
  parameter int                MODE_W      = 3,
  parameter logic [MODE_W-1:0] BOOT_MODE   = 3'b110,
  parameter logic [MODE_W-1:0] POR_MODE    = 3'b101
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              wren_pin,
  input  logic              wdt_req,
  output logic              int_rst_n,
  output logic [MODE_W-1:0] op_mode,
  output logic              boot_mode,
  output logic              boot_restart,
  output logic              bus_drv_en
);
  logic pin_sync, rst_hold, rel_valid, wdt_done;
  logic bus_en_q, bus_en_d;

  rbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync (
    .clk    (clk),
    .rst_ni (por_n),
    .d_i    (rst_pin_n),
    .q_o    (pin_sync)
  );

  rbc_seq #(.MIN_CYC(MIN_RST_CYC), .WDT_CYC(WDT_RST_CYC)) i_seq (
    .clk         (clk),
    .rst_ni      (por_n),
    .pin_lo_i    (!pin_sync),
    .wdt_req_i   (wdt_req),
    .rst_hold_o  (rst_hold),
    .rel_valid_o (rel_valid),
    .wdt_done_o  (wdt_done)
  );

  rbc_mode_latch #(.MODE_W(MODE_W), .BOOT_ENC(BOOT_MODE), .DEF_MODE(POR_MODE)) i_latch (
    .clk         (clk),
    .rst_ni      (por_n),
    .rel_valid_i (rel_valid),
    .wdt_done_i  (wdt_done),
    .mode_pins_i (mode_pins),
    .wren_i      (wren_pin),
    .mode_o      (op_mode),
    .boot_o      (boot_mode),
    .restart_o   (boot_restart)
  );

  always_comb bus_en_d = !rst_hold;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) bus_en_q <= 1'b0;
    else        bus_en_q <= bus_en_d;
  end

  assign int_rst_n  = !rst_hold;
  assign bus_drv_en = bus_en_q && !rst_hold;

  p_bus_off_r11: assert property (@(posedge clk) disable iff (!por_n)
    !int_rst_n |-> !bus_drv_en);

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
    ($past(int_rst_n) && int_rst_n) |-> ($stable(op_mode) && $stable(boot_mode)));

  p_boot_exit_r7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(boot_mode) |-> !$past(wren_pin));

  p_boot_entry_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(boot_mode) |-> ($past(wren_pin) && ($past(mode_pins) == BOOT_MODE)));

  p_restart_boot_r8: assert property (@(posedge clk) disable iff (!por_n)
    boot_restart |-> (boot_mode && int_rst_n));

  p_restart_pulse_r8: assert property (@(posedge clk) disable iff (!por_n)
    boot_restart |=> !boot_restart);
endmodule

// File: tb/test_rstboot_ctrl.sv
`timescale 1ns/1ps
module test_rstboot_ctrl;
  localparam int MIN_C = 20;
  localparam int WDT_C = 8;

  logic       clk = 1'b0;
  logic       por_n, rst_pin_n, wren_pin, wdt_req;
  logic [2:0] mode_pins;
  logic       int_rst_n, boot_mode, boot_restart, bus_drv_en;
  logic [2:0] op_mode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rstboot_ctrl i_rstboot_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .mode_pins(mode_pins),
    .wren_pin(wren_pin), .wdt_req(wdt_req), .int_rst_n(int_rst_n),
    .op_mode(op_mode), .boot_mode(boot_mode), .boot_restart(boot_restart),
    .bus_drv_en(bus_drv_en)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 200000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // {pins, we, len, exp_mode, exp_boot, exp_low}
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {3'b010, 1'b0, 8'd25, 3'b010, 1'b0, 8'd25},
    {3'b100, 1'b1, 8'd5,  3'b010, 1'b0, 8'd20},
    {3'b110, 1'b0, 8'd20, 3'b110, 1'b0, 8'd20},
    {3'b110, 1'b1, 8'd30, 3'b110, 1'b1, 8'd30},
    {3'b001, 1'b1, 8'd22, 3'b110, 1'b1, 8'd22},
    {3'b011, 1'b1, 8'd3,  3'b110, 1'b1, 8'd20},
    {3'b011, 1'b0, 8'd21, 3'b011, 1'b0, 8'd21}
  };

  int lows, lat, busbad, bus_rel, bus_next, rst_seen;

  task automatic ext_reset(input int len);
    int i;
    bit seen;
    i = 0; seen = 0; lows = 0; lat = 0; busbad = 0;
    @(negedge clk);
    rst_pin_n = 1'b0;
    while (i < 400) begin
      @(negedge clk);
      i++;
      if (!int_rst_n) begin
        lows++;
        if (!seen) begin lat = i; seen = 1; end
        if (bus_drv_en) busbad++;
      end
      if (i == len) rst_pin_n = 1'b1;
      if (seen && int_rst_n) break;
    end
    bus_rel = bus_drv_en;
    @(negedge clk);
    bus_next = bus_drv_en;
  endtask

  task automatic wdt_reset();
    int i;
    lows = 0; busbad = 0; rst_seen = 0; i = 0;
    @(negedge clk);
    wdt_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0;
    if (!int_rst_n) lows++;
    while (!int_rst_n && i < 100) begin
      if (bus_drv_en) busbad++;
      if (boot_restart) rst_seen++;
      @(negedge clk);
      i++;
      if (!int_rst_n) lows++;
    end
    bus_rel = boot_restart;
    for (int k = 0; k < 4; k++) begin
      if (boot_restart) rst_seen++;
      @(negedge clk);
    end
  endtask

  initial begin
    por_n = 1'b0; rst_pin_n = 1'b1; mode_pins = 3'b000; wren_pin = 1'b0; wdt_req = 1'b0;
    repeat (3) @(negedge clk);
    check(!int_rst_n,     "R12 int_rst_n", int_rst_n, 0);
    check(!bus_drv_en,    "R12 bus_drv_en", bus_drv_en, 0);
    check(!boot_restart,  "R12 boot_restart", boot_restart, 0);
    check(!boot_mode,     "R12 boot_mode", boot_mode, 0);
    check(op_mode == 3'b101, "R12 op_mode", op_mode, 5);
    por_n = 1'b1;
    mode_pins = 3'b110; wren_pin = 1'b1;
    for (int i = 0; i < 60 && !int_rst_n; i++) @(negedge clk);
    check(int_rst_n, "R12 power-on release", int_rst_n, 1);
    check(op_mode == 3'b101 && !boot_mode, "R12 no sample on power-on pulse", op_mode, 5);
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [23:0] e;
      e = VEC[v];
      mode_pins = e[23:21];
      wren_pin  = e[20];
      ext_reset(int'(e[19:12]));
      check(lat == 3, $sformatf("R1 vec %0d latency", v), lat, 3);
      check(lows == int'(e[7:0]), $sformatf("R2 vec %0d low width", v), lows, int'(e[7:0]));
      check(op_mode == e[11:9], $sformatf("R3/R4/R5/R6/R7 vec %0d op_mode", v), op_mode, int'(e[11:9]));
      check(boot_mode == e[8], $sformatf("R4/R5/R6/R7 vec %0d boot_mode", v), boot_mode, int'(e[8]));
      check(busbad == 0, $sformatf("R11 vec %0d bus on in reset", v), busbad, 0);
      check(bus_rel == 0 && bus_next == 1, $sformatf("R11 vec %0d bus enable timing", v),
            bus_rel * 2 + bus_next, 1);
      repeat (3) @(negedge clk);
    end

    // R10: pin changes while running have no effect (non-boot)
    mode_pins = 3'b110; wren_pin = 1'b1;
    repeat (5) @(negedge clk);
    mode_pins = 3'b000; wren_pin = 1'b0;
    repeat (5) @(negedge clk);
    check(op_mode == 3'b011 && !boot_mode && int_rst_n, "R10 non-boot pins ignored", op_mode, 3);

    // enter boot again
    mode_pins = 3'b110; wren_pin = 1'b1;
    ext_reset(20);
    check(boot_mode && op_mode == 3'b110, "R5 boot re-entry", op_mode, 6);
    // R10: drop write-enable and move pins while running in boot
    mode_pins = 3'b000; wren_pin = 1'b0;
    repeat (10) @(negedge clk);
    check(boot_mode && op_mode == 3'b110, "R10 boot pins ignored", boot_mode, 1);

    // R8: watchdog in boot with pins that would clear boot
    wdt_reset();
    check(lows == WDT_C, "R8 wdt reset width", lows, WDT_C);
    check(busbad == 0, "R11 bus off in wdt reset", busbad, 0);
    check(bus_rel == 1, "R8 restart in first cycle after reset", bus_rel, 1);
    check(rst_seen == 1, "R8 restart pulse count", rst_seen, 1);
    check(boot_mode && op_mode == 3'b110, "R8 boot kept, pins not read", op_mode, 6);

    // exit boot with write-enable low
    mode_pins = 3'b001; wren_pin = 1'b0;
    ext_reset(20);
    check(!boot_mode && op_mode == 3'b001, "R7 boot exit", op_mode, 1);

    // R9: watchdog outside boot
    mode_pins = 3'b110; wren_pin = 1'b1;
    wdt_reset();
    check(lows == WDT_C, "R9 wdt reset width", lows, WDT_C);
    check(rst_seen == 0, "R9 no restart outside boot", rst_seen, 0);
    check(!boot_mode && op_mode == 3'b001, "R9 mode unchanged", op_mode, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule